// File: doc/BRIEF.md
# Translation Cache Invalidation Matcher

This block is a small fully-associative tag array for an I/O address translation cache, with an engine that applies one invalidation request to it. Each slot holds a valid bit, the translation stage (first or second), a leaf or non-leaf level flag, a global-mapping flag, a guest flag, a process-context ID, a guest-context ID and a 4 KiB page number.

A request names one of two command kinds: a first-stage kind (per address space) or a second-stage kind (guest physical). It also carries four qualifiers:
- address-valid
- guest-valid
- process-ID-valid
- non-leaf

It also carries the two IDs, a page-number base and a don't-care mask. Once accepted, the engine visits one slot per clock and clears each valid slot that the selection rules pick. It then pulses `done` for one cycle. A fill port writes a whole slot tag when the engine is idle. A probe port reads any slot back.

Top module: `atc_inval_unit`

## Requirements
- R1: After reset every slot reads back invalid, and `busy` and `done` are 0.
- R2: A fill (`fill_valid`=1 while `busy`=0) writes the whole tag at `fill_idx`. The probe port shows it from the next cycle. `fill_ready` is the inverse of `busy`. A fill presented while `busy`=1 has no effect.
- R3: A request is taken when `req_valid`=1 and `busy`=0. `busy` is then high for exactly NUM_ENTRIES cycles, and `done` is high for the single cycle that follows. A request presented while `busy`=1 is ignored.
- R4: First-stage kind (`req_gvma`=0) with address-valid=1 and non-leaf=0 clears only leaf slots whose page matches the address.
- R5: First-stage kind with address-valid=1 and non-leaf=1 clears both leaf and non-leaf slots whose page matches.
- R6: First-stage kind with address-valid=0 ignores the address and the non-leaf qualifier. Every slot meeting the ID rules is cleared, at every level.
- R7: First-stage kind with guest-valid=0 picks only slots with the guest flag 0. With process-ID-valid=0 it takes any process ID, global slots included. With process-ID-valid=1 the process ID must match and global slots are kept.
- R8: First-stage kind with guest-valid=1 picks only slots with the guest flag 1 and an equal guest ID. The process-ID rule of R7 applies as well.
- R9: Second-stage kind (`req_gvma`=1) with guest-valid=0 clears every second-stage slot. Address-valid, non-leaf, the IDs and the address are ignored.
- R10: Second-stage kind with guest-valid=1 needs an equal guest ID. With address-valid=1, the page must match, and only leaf slots are cleared unless non-leaf=1. With address-valid=0, all levels are cleared.
- R11: A page matches when `(slot_vpn & ~req_mask) == (req_base & ~req_mask)`. A 1 in the mask marks a don't-care bit.
- R12: The first-stage kind never clears a slot whose stage bit is 1 (second). The second-stage kind never clears a slot whose stage bit is 0 (first).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_valid | input | 1 | Write a slot tag |
| fill_idx | input | IDX_W | Slot to write |
| fill_v | input | 1 | Valid bit to write |
| fill_stage | input | 1 | Stage to write (0 first, 1 second) |
| fill_leaf | input | 1 | Leaf flag to write |
| fill_glob | input | 1 | Global flag to write |
| fill_gv | input | 1 | Guest flag to write |
| fill_pscid | input | PSCID_W | Process ID to write |
| fill_gscid | input | GSCID_W | Guest ID to write |
| fill_vpn | input | VPN_W | Page number to write |
| fill_ready | output | 1 | Fill accepted this cycle when high |
| req_valid | input | 1 | Invalidation request strobe |
| req_gvma | input | 1 | 0 first-stage kind, 1 second-stage kind |
| req_av | input | 1 | Address-valid qualifier |
| req_gv | input | 1 | Guest-valid qualifier |
| req_pscv | input | 1 | Process-ID-valid qualifier |
| req_nl | input | 1 | Non-leaf qualifier |
| req_pscid | input | PSCID_W | Process ID of the request |
| req_gscid | input | GSCID_W | Guest ID of the request |
| req_base | input | VPN_W | Page-number base |
| req_mask | input | VPN_W | Don't-care page-number bits |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| rd_idx | input | IDX_W | Probe slot index |
| rd_v | output | 1 | Probed valid bit |
| rd_stage | output | 1 | Probed stage |
| rd_leaf | output | 1 | Probed leaf flag |
| rd_glob | output | 1 | Probed global flag |
| rd_gv | output | 1 | Probed guest flag |
| rd_pscid | output | PSCID_W | Probed process ID |
| rd_gscid | output | GSCID_W | Probed guest ID |
| rd_vpn | output | VPN_W | Probed page number |

## Verification
A fill and a second request can both arrive while a walk is clearing slots. The bench provokes this by raising a competing request together with a fill into an empty slot, in the middle of a walk. It judges the outcome from the probe port once `done` has pulsed: the fill must not have landed, and the slots that only the second request would have cleared must still be valid. The walk length and the single-cycle `done` are timed in the same run.

// File: rtl/atc_inval_pkg.sv
package atc_inval_pkg;
  localparam int PSCID_W = 20;
  localparam int GSCID_W = 16;
  localparam int VPN_W   = 27;

  typedef enum logic {STG_FIRST = 1'b0, STG_SECOND = 1'b1} stage_e;

  typedef struct packed {
    logic               valid;
    stage_e             stage;
    logic               leaf;
    logic               glob;
    logic               gv;
    logic [PSCID_W-1:0] pscid;
    logic [GSCID_W-1:0] gscid;
    logic [VPN_W-1:0]   vpn;
  } atc_tag_t;

  typedef struct packed {
    logic               is_gvma;
    logic               av;
    logic               gv;
    logic               pscv;
    logic               nl;
    logic [PSCID_W-1:0] pscid;
    logic [GSCID_W-1:0] gscid;
    logic [VPN_W-1:0]   base;
    logic [VPN_W-1:0]   mask;
  } inval_req_t;
endpackage

// File: rtl/atc_rst_sync.sv
module atc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/atc_inval_match.sv
module atc_inval_match
  import atc_inval_pkg::*;
(
  input  atc_tag_t   tag,
  input  inval_req_t req,
  output logic       hit
);
  logic addr_hit, level_ok, gscid_eq, pscid_eq;
  logic first_sel, second_sel;

  always_comb begin
    addr_hit = ((tag.vpn ^ req.base) & ~req.mask) == '0;
    level_ok = tag.leaf | req.nl;
    gscid_eq = tag.gscid == req.gscid;
    pscid_eq = tag.pscid == req.pscid;

    first_sel = (tag.stage == STG_FIRST)
              & (req.gv ? (tag.gv & gscid_eq) : ~tag.gv)
              & (req.pscv ? (pscid_eq & ~tag.glob) : 1'b1)
              & (req.av ? (addr_hit & level_ok) : 1'b1);

    second_sel = (tag.stage == STG_SECOND)
               & (~req.gv | (gscid_eq & (~req.av | (addr_hit & level_ok))));

    hit = tag.valid & (req.is_gvma ? second_sel : first_sel);
  end
endmodule

// File: rtl/atc_tag_store.sv
module atc_tag_store
  import atc_inval_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  atc_tag_t               wr_tag,
  input  logic                   clr_en,
  input  logic [IDX_W-1:0]       clr_idx,
  input  logic [IDX_W-1:0]       walk_idx,
  output atc_tag_t               walk_tag,
  input  logic [IDX_W-1:0]       probe_idx,
  output atc_tag_t               probe_tag,
  output logic [NUM_ENTRIES-1:0] valid_vec
);
  logic [NUM_ENTRIES-1:0] valid_q, valid_d;
  atc_tag_t               tags_q [NUM_ENTRIES];

  always_comb begin
    valid_d = valid_q;
    if (wr_en)  valid_d[wr_idx]  = wr_tag.valid;
    if (clr_en) valid_d[clr_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (slot_we) tags_q[i] <= wr_tag;
    end
  end

  always_comb begin
    walk_tag        = tags_q[walk_idx];
    walk_tag.valid  = valid_q[walk_idx];
    probe_tag       = tags_q[probe_idx];
    probe_tag.valid = valid_q[probe_idx];
  end

  assign valid_vec = valid_q;
endmodule

// File: rtl/atc_walk_ctrl.sv
module atc_walk_ctrl
  import atc_inval_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  inval_req_t       req_in,
  output inval_req_t       req_q,
  output logic [IDX_W-1:0] walk_idx,
  output logic             busy,
  output logic             done
);
  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_DONE} walk_st_e;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  walk_st_e         st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             accept;

  assign accept = req_valid && (st_q != ST_WALK);

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    case (st_q)
      ST_WALK: begin
        if (idx_q == LAST_IDX) st_d = ST_DONE;
        else                   idx_d = idx_q + 1'b1;
      end
      default: begin
        st_d = ST_IDLE;
        if (accept) begin
          st_d  = ST_WALK;
          idx_d = '0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) req_q <= req_in;
  end

  assign walk_idx = idx_q;
  assign busy     = (st_q == ST_WALK);
  assign done     = (st_q == ST_DONE);
endmodule

// File: rtl/atc_inval_unit.sv
module atc_inval_unit
  import atc_inval_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_valid,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic               fill_v,
  input  logic               fill_stage,
  input  logic               fill_leaf,
  input  logic               fill_glob,
  input  logic               fill_gv,
  input  logic [PSCID_W-1:0] fill_pscid,
  input  logic [GSCID_W-1:0] fill_gscid,
  input  logic [VPN_W-1:0]   fill_vpn,
  output logic               fill_ready,
  input  logic               req_valid,
  input  logic               req_gvma,
  input  logic               req_av,
  input  logic               req_gv,
  input  logic               req_pscv,
  input  logic               req_nl,
  input  logic [PSCID_W-1:0] req_pscid,
  input  logic [GSCID_W-1:0] req_gscid,
  input  logic [VPN_W-1:0]   req_base,
  input  logic [VPN_W-1:0]   req_mask,
  output logic               busy,
  output logic               done,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               rd_v,
  output logic               rd_stage,
  output logic               rd_leaf,
  output logic               rd_glob,
  output logic               rd_gv,
  output logic [PSCID_W-1:0] rd_pscid,
  output logic [GSCID_W-1:0] rd_gscid,
  output logic [VPN_W-1:0]   rd_vpn
);
  logic                   rst_n_int;
  inval_req_t             req_in, req_q;
  atc_tag_t               fill_tag, walk_tag, probe_tag;
  logic [IDX_W-1:0]       walk_idx;
  logic                   walk_hit, clr_en, wr_en;
  logic [NUM_ENTRIES-1:0] valid_vec;

  atc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int));

  always_comb begin
    req_in.is_gvma = req_gvma;
    req_in.av      = req_av;
    req_in.gv      = req_gv;
    req_in.pscv    = req_pscv;
    req_in.nl      = req_nl;
    req_in.pscid   = req_pscid;
    req_in.gscid   = req_gscid;
    req_in.base    = req_base;
    req_in.mask    = req_mask;

    fill_tag.valid = fill_v;
    fill_tag.stage = stage_e'(fill_stage);
    fill_tag.leaf  = fill_leaf;
    fill_tag.glob  = fill_glob;
    fill_tag.gv    = fill_gv;
    fill_tag.pscid = fill_pscid;
    fill_tag.gscid = fill_gscid;
    fill_tag.vpn   = fill_vpn;
  end

  atc_walk_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) u_ctrl (
    .clk(clk), .rst_n(rst_n_int), .req_valid(req_valid), .req_in(req_in),
    .req_q(req_q), .walk_idx(walk_idx), .busy(busy), .done(done)
  );

  atc_inval_match u_match (.tag(walk_tag), .req(req_q), .hit(walk_hit));

  assign fill_ready = ~busy;
  assign wr_en      = fill_valid & ~busy;
  assign clr_en     = busy & walk_hit;

  atc_tag_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n_int),
    .wr_en(wr_en), .wr_idx(fill_idx), .wr_tag(fill_tag),
    .clr_en(clr_en), .clr_idx(walk_idx),
    .walk_idx(walk_idx), .walk_tag(walk_tag),
    .probe_idx(rd_idx), .probe_tag(probe_tag),
    .valid_vec(valid_vec)
  );

  assign rd_v     = probe_tag.valid;
  assign rd_stage = probe_tag.stage;
  assign rd_leaf  = probe_tag.leaf;
  assign rd_glob  = probe_tag.glob;
  assign rd_gv    = probe_tag.gv;
  assign rd_pscid = probe_tag.pscid;
  assign rd_gscid = probe_tag.gscid;
  assign rd_vpn   = probe_tag.vpn;
endmodule

// File: rtl/atc_inval_checker.sv
module atc_inval_checker #(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES),
  localparam int CNT_W = $clog2(NUM_ENTRIES + 2)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   busy,
  input logic                   done,
  input logic                   fill_valid,
  input logic [IDX_W-1:0]       fill_idx,
  input logic [NUM_ENTRIES-1:0] valid_vec
);
  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  // R3: done lasts a single cycle
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: the walk spans exactly one cycle per slot
  a_r3_walk_length: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_cnt == CNT_W'(NUM_ENTRIES)));

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_chk
    // R2: a slot becomes valid only through a fill taken while idle
    a_r2_fill_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_vec[i]) |-> ($past(fill_valid) && !$past(busy)
                               && ($past(fill_idx) == IDX_W'(i))));
    // R3: a slot is cleared only by a walk or by a fill of that slot
    a_r3_clear_source: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(valid_vec[i]) |-> ($past(busy)
                               || ($past(fill_valid) && ($past(fill_idx) == IDX_W'(i)))));
  end
endmodule

bind atc_inval_unit atc_inval_checker #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .fill_valid(fill_valid), .fill_idx(fill_idx), .valid_vec(valid_vec)
);

// File: tb/tb_atc_inval_unit.sv
`timescale 1ns/1ps
module tb_atc_inval_unit;
  import atc_inval_pkg::*;

  localparam int N     = 16;
  localparam int IDX_W = $clog2(N);

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic               fill_valid, fill_v, fill_stage, fill_leaf, fill_glob, fill_gv;
  logic [IDX_W-1:0]   fill_idx, rd_idx;
  logic [PSCID_W-1:0] fill_pscid, req_pscid, rd_pscid;
  logic [GSCID_W-1:0] fill_gscid, req_gscid, rd_gscid;
  logic [VPN_W-1:0]   fill_vpn, req_base, req_mask, rd_vpn;
  logic               fill_ready, req_valid, req_gvma, req_av, req_gv, req_pscv, req_nl;
  logic               busy, done, rd_v, rd_stage, rd_leaf, rd_glob, rd_gv;

  atc_inval_unit #(.NUM_ENTRIES(N)) dut (.*);

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  atc_tag_t model [N];

  localparam logic [VPN_W-1:0] A = 27'h0123450;

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit ref_clears(input atc_tag_t e, input inval_req_t r);
    bit page_eq, ids_ok, lvl_ok;
    if (!e.valid) return 0;
    page_eq = ((e.vpn & ~r.mask) == (r.base & ~r.mask));
    lvl_ok  = r.nl || e.leaf;
    if (!r.is_gvma) begin
      if (e.stage != STG_FIRST) return 0;
      if (r.gv) ids_ok = e.gv && (e.gscid == r.gscid);
      else      ids_ok = !e.gv;
      if (r.pscv && (e.glob || e.pscid != r.pscid)) ids_ok = 0;
      if (!r.av) return ids_ok;
      return ids_ok && page_eq && lvl_ok;
    end
    if (e.stage != STG_SECOND) return 0;
    if (!r.gv) return 1;
    if (e.gscid != r.gscid) return 0;
    if (!r.av) return 1;
    return page_eq && lvl_ok;
  endfunction

  task automatic do_fill(input int idx, input atc_tag_t t);
    fill_valid = 1; fill_idx = IDX_W'(idx); fill_v = t.valid; fill_stage = t.stage;
    fill_leaf = t.leaf; fill_glob = t.glob; fill_gv = t.gv;
    fill_pscid = t.pscid; fill_gscid = t.gscid; fill_vpn = t.vpn;
    @(negedge clk);
    fill_valid = 0;
    model[idx] = t;
  endtask

  function automatic atc_tag_t mk(input bit v, input bit s, input bit lf, input bit gl,
                                  input bit gv, input int ps, input int gs, input logic [VPN_W-1:0] vpn);
    atc_tag_t t;
    t.valid = v; t.stage = stage_e'(s); t.leaf = lf; t.glob = gl; t.gv = gv;
    t.pscid = PSCID_W'(ps); t.gscid = GSCID_W'(gs); t.vpn = vpn;
    return t;
  endfunction

  function automatic inval_req_t mkr(input bit g, input bit av, input bit gv, input bit pscv,
                                     input bit nl, input int ps, input int gs,
                                     input logic [VPN_W-1:0] base, input logic [VPN_W-1:0] mask);
    inval_req_t r;
    r.is_gvma = g; r.av = av; r.gv = gv; r.pscv = pscv; r.nl = nl;
    r.pscid = PSCID_W'(ps); r.gscid = GSCID_W'(gs); r.base = base; r.mask = mask;
    return r;
  endfunction

  task automatic drive_req(input inval_req_t r);
    req_gvma = r.is_gvma; req_av = r.av; req_gv = r.gv; req_pscv = r.pscv; req_nl = r.nl;
    req_pscid = r.pscid; req_gscid = r.gscid; req_base = r.base; req_mask = r.mask;
  endtask

  task automatic compare_all(input string tag);
    for (int i = 0; i < N; i++) begin
      rd_idx = IDX_W'(i);
      #1;
      check(tag, $sformatf("slot %0d valid", i), rd_v, model[i].valid);
      if (model[i].valid) begin
        check(tag, $sformatf("slot %0d vpn", i), rd_vpn, model[i].vpn);
        check(tag, $sformatf("slot %0d ids", i), {rd_pscid, rd_gscid},
              {model[i].pscid, model[i].gscid});
        check(tag, $sformatf("slot %0d flags", i), {rd_stage, rd_leaf, rd_glob, rd_gv},
              {model[i].stage, model[i].leaf, model[i].glob, model[i].gv});
      end
    end
  endtask

  task automatic run_req(input string tag, input inval_req_t r, input bit poke);
    int cnt;
    drive_req(r);
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < N; i++) if (ref_clears(model[i], r)) model[i].valid = 0;
    cnt = 0;
    while (!done) begin
      if (busy) cnt++;
      if (poke && cnt == 3) begin
        check("R2", "fill_ready while busy", fill_ready, 0);
        drive_req(mkr(1, 0, 0, 0, 0, 0, 0, 0, 0));
        req_valid = 1;
        fill_valid = 1; fill_idx = IDX_W'(12); fill_v = 1; fill_stage = 1;
        fill_leaf = 1; fill_glob = 0; fill_gv = 0; fill_pscid = 0; fill_gscid = 5; fill_vpn = A;
      end else begin
        req_valid = 0; fill_valid = 0;
      end
      @(negedge clk);
      if (cnt > N + 4) break;
    end
    req_valid = 0; fill_valid = 0;
    check("R3", "busy cycles", cnt, N);
    check("R3", "done high", done, 1);
    @(negedge clk);
    check("R3", "done single cycle", done, 0);
    compare_all(tag);
  endtask

  task automatic fill_std();
    do_fill(0,  mk(1, 0, 1, 0, 0, 1, 0, A));
    do_fill(1,  mk(1, 0, 0, 0, 0, 1, 0, A));
    do_fill(2,  mk(1, 0, 1, 1, 0, 2, 0, A));
    do_fill(3,  mk(1, 0, 1, 0, 0, 1, 0, A + 1));
    do_fill(4,  mk(1, 0, 1, 0, 1, 1, 5, A));
    do_fill(5,  mk(1, 0, 1, 0, 1, 1, 6, A));
    do_fill(6,  mk(1, 1, 1, 0, 0, 0, 5, A));
    do_fill(7,  mk(1, 1, 0, 0, 0, 0, 5, A));
    do_fill(8,  mk(1, 1, 1, 0, 0, 0, 6, A + 1));
    do_fill(9,  mk(1, 0, 0, 1, 1, 1, 5, A));
    for (int i = 10; i < N; i++) do_fill(i, mk(0, 0, 0, 0, 0, 0, 0, 0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; fill_valid = 0; req_valid = 0; rd_idx = '0;
    fill_idx = '0; fill_v = 0; fill_stage = 0; fill_leaf = 0; fill_glob = 0; fill_gv = 0;
    fill_pscid = '0; fill_gscid = '0; fill_vpn = '0;
    drive_req(mkr(0, 0, 0, 0, 0, 0, 0, 0, 0));
    for (int i = 0; i < N; i++) model[i] = mk(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    check("R1", "busy after reset", busy, 0);
    check("R1", "done after reset", done, 0);
    compare_all("R1");

    fill_std();
    compare_all("R2");

    run_req("R4",  mkr(0, 1, 0, 0, 0, 0, 0, A, 0), 0);
    fill_std(); run_req("R5",  mkr(0, 1, 0, 0, 1, 0, 0, A, 0), 0);
    fill_std(); run_req("R11", mkr(0, 1, 0, 0, 0, 0, 0, A, 1), 0);
    fill_std(); run_req("R6",  mkr(0, 0, 0, 0, 0, 0, 0, A + 7, 0), 0);
    fill_std(); run_req("R7",  mkr(0, 1, 0, 1, 1, 1, 0, A, 1), 0);
    fill_std(); run_req("R8",  mkr(0, 1, 1, 0, 1, 0, 5, A, 0), 0);
    fill_std(); run_req("R8",  mkr(0, 0, 1, 1, 0, 1, 5, 0, 0), 0);
    fill_std(); run_req("R9",  mkr(1, 1, 0, 1, 0, 3, 3, A + 9, 0), 0);
    fill_std(); run_req("R10", mkr(1, 1, 1, 0, 0, 0, 5, A, 0), 0);
    fill_std(); run_req("R10", mkr(1, 1, 1, 0, 1, 0, 5, A, 0), 0);
    fill_std(); run_req("R10", mkr(1, 0, 1, 0, 0, 0, 6, 0, 0), 0);
    fill_std(); run_req("R12", mkr(1, 0, 0, 0, 0, 0, 0, 0, '1), 0);
    fill_std(); run_req("R12", mkr(0, 0, 0, 0, 1, 0, 0, 0, '1), 0);
    fill_std(); run_req("R3",  mkr(0, 0, 0, 0, 0, 0, 0, 0, 0), 1);

    for (int it = 0; it < 40; it++) begin
      inval_req_t r;
      string tag;
      bit [7:0] mk_sel;
      void'($urandom(it == 0 ? 32'd1234 : 32'd0));
      for (int i = 0; i < N; i++) begin
        mk_sel = 8'($urandom);
        do_fill(i, mk(mk_sel[0] | mk_sel[1], mk_sel[2], mk_sel[3], mk_sel[4], mk_sel[5],
                      1 + mk_sel[6], 5 + mk_sel[7], A | VPN_W'($urandom_range(0, 7))));
      end
      mk_sel = 8'($urandom);
      r = mkr(mk_sel[0], mk_sel[1], mk_sel[2], mk_sel[3], mk_sel[4], 1 + mk_sel[5],
              5 + mk_sel[6], A | VPN_W'($urandom_range(0, 7)),
              VPN_W'((1 << $urandom_range(0, 3)) - 1));
      if (r.is_gvma) tag = r.gv ? "R10" : "R9";
      else if (!r.av) tag = "R6";
      else tag = r.nl ? "R5" : "R4";
      run_req(tag, r, 0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule